// File: doc/BRIEF.md
# Memory-Mapped Port I/O Bridge

This block lets a processor with a 32-bit memory-mapped bus reach peripherals that sit on a legacy port I/O bus with a 16-bit port number. It claims one fixed 64 KB window of host address space. Any byte, halfword or word access that falls inside the window becomes a single port read or write of the same size. The port number is the offset of the access inside the window.

The host holds its request until the bridge raises `hostReady` for one cycle. The bridge keeps `hostReady` low while the port cycle is outstanding, so only one transaction is in flight at a time. A static `bigEndian` pin selects byte-order correction. When it is high, multi-byte data is byte-reversed in both directions. Byte accesses always pass through unchanged.

An access that misses the window never reaches the port bus. A missed write simply completes. A missed read completes with zero data and a one-cycle error flag.

Top module: `legacy_io_bridge`

## Requirements
- R1: A port access (portRd or portWr high) is started only when hostAddr[31:16] equals 16'h1400. The window ends at 0x1400FFFF, and 0x13FFFFFF and 0x14010000 lie outside it.
- R2: During a port access, portAddr equals hostAddr[15:0] and portSize equals hostSize (0 = byte, 1 = halfword, 2 = word). Both stay stable until portAck.
- R3: With bigEndian low, portWdata carries hostWdata masked to the access size: bits [7:0] for a byte, [15:0] for a halfword, [31:0] for a word. All unused upper bits are zero.
- R4: With bigEndian high, halfword write data has its two low bytes exchanged and word write data has all four bytes reversed. Byte write data is unchanged.
- R5: Read data from portRdata is masked to the access size and zero-extended onto hostRdata. With bigEndian high, it is byte-swapped by the same rule as R4.
- R6: hostReady stays low from the request until the port acknowledges. It rises in the cycle after portAck is sampled and is high for exactly one cycle. portRd or portWr stays high until portAck.
- R7: A write outside the window raises no port strobe. It completes with hostReady for one cycle, with hostErr low.
- R8: A read outside the window raises no port strobe. It completes with hostRdata zero and hostErr high for the single cycle in which hostReady is high.
- R9: After reset, hostReady, hostErr, portRd, portWr and hostRdata are all zero.
- R10: An in-window access never raises hostErr. When hostRd and hostWr are both high, the access is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bigEndian | input | 1 | Static byte-order select, high = swap multi-byte data |
| hostAddr | input | 32 | Host byte address, held until hostReady |
| hostWdata | input | 32 | Host write data, low-aligned |
| hostSize | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| hostRd | input | 1 | Host read request, held until hostReady |
| hostWr | input | 1 | Host write request, held until hostReady |
| hostRdata | output | 32 | Read result, valid while hostReady is high |
| hostReady | output | 1 | One-cycle completion pulse |
| hostErr | output | 1 | Out-of-window read flag, coincides with hostReady |
| portAddr | output | 16 | Port number |
| portSize | output | 2 | Port access size |
| portWdata | output | 32 | Port write data after lane correction |
| portRdata | input | 32 | Port read data, sampled with portAck |
| portRd | output | 1 | Port read strobe |
| portWr | output | 1 | Port write strobe |
| portAck | input | 1 | Port acknowledge, ends the port access |

## Verification
A sequencer stuck in its wait state shows up as hostReady never rising after portAck, and the bench catches it within the same access. A wrong completion state shows up as a ready pulse that lasts two cycles or arrives before the acknowledge. A stale captured size or address register is visible on portAddr, portSize or portWdata in the first cycle of the port strobe. A stale read register shows up as nonzero hostRdata on the out-of-window read that follows an in-window read.

// File: rtl/iobr_pkg.sv
package iobr_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } bridgeStateT;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;   // latch host request fields
    logic takeRead;  // latch corrected port read data
    logic zeroRead;  // clear read result (missed read)
  } ctrlStrobeT;

  // mask to access size, then reverse the active bytes when swap is set
  function automatic logic [31:0] laneFix(input logic [31:0] d,
                                          input logic [1:0]  sz,
                                          input logic        swap);
    logic [31:0] masked;
    logic [31:0] res;
    int          nBytes;
    nBytes = (sz == SZ_BYTE) ? 1 : ((sz == SZ_HALF) ? 2 : 4);
    masked = '0;
    res    = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < nBytes) masked[i*8 +: 8] = d[i*8 +: 8];
    end
    for (int i = 0; i < 4; i++) begin
      if (i < nBytes) begin
        if (swap) res[i*8 +: 8] = masked[(nBytes-1-i)*8 +: 8];
        else      res[i*8 +: 8] = masked[i*8 +: 8];
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/io_bridge_ctrl.sv
module io_bridge_ctrl
  import iobr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostRd,
  input  logic       hostWr,
  input  logic       inWindow,
  input  logic       portAck,
  output ctrlStrobeT strobes,
  output logic       portRd,
  output logic       portWr,
  output logic       hostReady,
  output logic       hostErr
);

  bridgeStateT stateQ, stateD;
  logic        isWriteQ;
  logic        errQ;
  logic        request;

  assign request = hostRd | hostWr;

  always_comb begin
    stateD           = stateQ;
    strobes.capture  = 1'b0;
    strobes.takeRead = 1'b0;
    strobes.zeroRead = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (request) begin
          strobes.capture  = 1'b1;
          strobes.zeroRead = !inWindow && !hostWr;
          stateD           = inWindow ? ST_BUSY : ST_DONE;
        end
      end
      ST_BUSY: begin
        if (portAck) begin
          strobes.takeRead = !isWriteQ;
          stateD           = ST_DONE;
        end
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      isWriteQ <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_IDLE && request) begin
        isWriteQ <= hostWr;
        errQ     <= !inWindow && !hostWr;
      end
    end
  end

  assign portRd    = (stateQ == ST_BUSY) && !isWriteQ;
  assign portWr    = (stateQ == ST_BUSY) && isWriteQ;
  assign hostReady = (stateQ == ST_DONE);
  assign hostErr   = (stateQ == ST_DONE) && errQ;

  // R6: acknowledge during a port access completes the host access next cycle
  a_r6_ready_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    ((portRd || portWr) && portAck) |=> hostReady);

  // R6: ready is a single-cycle pulse
  a_r6_ready_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |=> !hostReady);

  // R6: strobe held until acknowledged
  a_r6_strobe_held: assert property (@(posedge clk) disable iff (!rstN)
    ((portRd || portWr) && !portAck) |=> (portRd || portWr));

  // R8: error only alongside completion
  a_r8_err_with_ready: assert property (@(posedge clk) disable iff (!rstN)
    hostErr |-> hostReady);

  // R1: never both port strobes
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(portRd && portWr));

endmodule

// File: rtl/io_bridge_datapath.sv
module io_bridge_datapath
  import iobr_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          PORT_AW  = 16,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] WIN_BASE = 32'h1400_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bigEndian,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [1:0]        hostSize,
  input  logic [DATA_W-1:0] portRdata,
  input  ctrlStrobeT        strobes,
  output logic              inWindow,
  output logic [PORT_AW-1:0] portAddr,
  output logic [1:0]        portSize,
  output logic [DATA_W-1:0] portWdata,
  output logic [DATA_W-1:0] hostRdata
);

  localparam int TAG_W = ADDR_W - PORT_AW;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:PORT_AW];

  logic [PORT_AW-1:0] addrQ;
  logic [1:0]         sizeQ;
  logic [DATA_W-1:0]  wdataQ;
  logic [DATA_W-1:0]  rdataQ;

  assign inWindow = (hostAddr[ADDR_W-1:PORT_AW] == WIN_TAG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      sizeQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (strobes.capture) begin
        addrQ  <= hostAddr[PORT_AW-1:0];
        sizeQ  <= hostSize;
        wdataQ <= laneFix(hostWdata, hostSize, bigEndian);
      end
      if (strobes.zeroRead)      rdataQ <= '0;
      else if (strobes.takeRead) rdataQ <= laneFix(portRdata, sizeQ, bigEndian);
    end
  end

  assign portAddr  = addrQ;
  assign portSize  = sizeQ;
  assign portWdata = wdataQ;
  assign hostRdata = rdataQ;

  // R5: a byte read result never carries bits above the low byte
  a_r5_zero_extend: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.takeRead && sizeQ == SZ_BYTE) |=> (hostRdata[DATA_W-1:8] == '0));

  // R8: a missed read leaves zero on the read bus
  a_r8_zero_read: assert property (@(posedge clk) disable iff (!rstN)
    strobes.zeroRead |=> (hostRdata == '0));

endmodule

// File: rtl/legacy_io_bridge.sv
module legacy_io_bridge
  import iobr_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'h1400_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bigEndian,
  input  logic [31:0] hostAddr,
  input  logic [31:0] hostWdata,
  input  logic [1:0]  hostSize,
  input  logic        hostRd,
  input  logic        hostWr,
  output logic [31:0] hostRdata,
  output logic        hostReady,
  output logic        hostErr,
  output logic [15:0] portAddr,
  output logic [1:0]  portSize,
  output logic [31:0] portWdata,
  input  logic [31:0] portRdata,
  output logic        portRd,
  output logic        portWr,
  input  logic        portAck
);

  ctrlStrobeT strobes;
  logic       inWindow;

  io_bridge_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostRd    (hostRd),
    .hostWr    (hostWr),
    .inWindow  (inWindow),
    .portAck   (portAck),
    .strobes   (strobes),
    .portRd    (portRd),
    .portWr    (portWr),
    .hostReady (hostReady),
    .hostErr   (hostErr)
  );

  io_bridge_datapath #(
    .ADDR_W   (32),
    .PORT_AW  (16),
    .DATA_W   (32),
    .WIN_BASE (WIN_BASE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .bigEndian (bigEndian),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .hostSize  (hostSize),
    .portRdata (portRdata),
    .strobes   (strobes),
    .inWindow  (inWindow),
    .portAddr  (portAddr),
    .portSize  (portSize),
    .portWdata (portWdata),
    .hostRdata (hostRdata)
  );

  // R2: port fields stay stable while waiting for the acknowledge
  a_r2_fields_stable: assert property (@(posedge clk) disable iff (!rstN)
    ((portRd || portWr) && !portAck) |=>
      ($stable(portAddr) && $stable(portSize) && $stable(portWdata)));

endmodule

// File: tb/sim_legacy_io_bridge.sv
`timescale 1ns/1ps
module sim_legacy_io_bridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bigEndian = 1'b0;
  logic [31:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [1:0]  hostSize = '0;
  logic        hostRd = 1'b0;
  logic        hostWr = 1'b0;
  logic [31:0] hostRdata;
  logic        hostReady;
  logic        hostErr;
  logic [15:0] portAddr;
  logic [1:0]  portSize;
  logic [31:0] portWdata;
  logic [31:0] portRdata = '0;
  logic        portRd;
  logic        portWr;
  logic        portAck = 1'b0;

  int nTests = 0;
  int nFail  = 0;

  // observations of the last access
  logic        oStrobe, oReadyEarly, oErr, oWrDir, oDropped;
  logic [15:0] oAddr;
  logic [1:0]  oSize;
  logic [31:0] oWdata, oRdata;
  int          oStrobeCycles;

  always #2.5 clk = ~clk;

  legacy_io_bridge u0 (
    .clk(clk), .rstN(rstN), .bigEndian(bigEndian),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostSize(hostSize),
    .hostRd(hostRd), .hostWr(hostWr), .hostRdata(hostRdata),
    .hostReady(hostReady), .hostErr(hostErr), .portAddr(portAddr),
    .portSize(portSize), .portWdata(portWdata), .portRdata(portRdata),
    .portRd(portRd), .portWr(portWr), .portAck(portAck)
  );

  initial begin
    #200000;
    nTests++; nFail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // independent model of lane correction
  function automatic logic [31:0] expLane(input logic [31:0] d, input logic [1:0] sz,
                                          input logic be);
    case (sz)
      2'd0:    return {24'h0, d[7:0]};
      2'd1:    return be ? {16'h0, d[7:0], d[15:8]} : {16'h0, d[15:0]};
      default: return be ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
    endcase
  endfunction

  task automatic access(input bit wr, input bit rd, input logic [31:0] addr,
                        input logic [1:0] sz, input logic [31:0] wd,
                        input logic [31:0] resp, input int delay);
    int waits = 0;
    bit acked = 0;
    oStrobe = 0; oReadyEarly = 0; oErr = 0; oWrDir = 0; oDropped = 0;
    oAddr = '0; oSize = '0; oWdata = '0; oRdata = '0; oStrobeCycles = 0;
    @(negedge clk);
    hostAddr = addr; hostSize = sz; hostWdata = wd; hostWr = wr; hostRd = rd;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (hostReady) begin
        oRdata = hostRdata; oErr = hostErr;
        hostRd = 0; hostWr = 0; portAck = 0;
        @(negedge clk);
        oDropped = !hostReady;
        return;
      end
      portAck = 0;
      if (portRd || portWr) begin
        if (!oStrobe) begin
          oAddr = portAddr; oSize = portSize; oWdata = portWdata; oWrDir = portWr;
        end
        oStrobe = 1;
        oStrobeCycles++;
        if (waits == delay) begin
          portAck = 1; portRdata = resp; acked = 1;
        end
        waits++;
      end else if (acked) begin
        oReadyEarly = 1;
      end
    end
    hostRd = 0; hostWr = 0;
  endtask

  task automatic tReset();
    @(negedge clk);
    check(!hostReady && !hostErr && !portRd && !portWr, "R9 control outputs",
          {28'h0, hostReady, hostErr, portRd, portWr}, 32'h0);
    check(hostRdata == 0, "R9 read data", hostRdata, 32'h0);
  endtask

  task automatic tWrite(input logic be, input logic [31:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, input string req);
    bigEndian = be;
    access(1, 0, addr, sz, wd, 32'h0, 1);
    check(oStrobe && oWrDir, {req, " R1 write strobe"}, {31'h0, oStrobe}, 32'h1);
    check(oAddr == addr[15:0] && oSize == sz, {req, " R2 addr/size"},
          {14'h0, oSize, oAddr}, {14'h0, sz, addr[15:0]});
    check(oWdata == expLane(wd, sz, be), {req, " write data"}, oWdata, expLane(wd, sz, be));
    check(!oErr && oDropped, {req, " R10 no err, R6 one-cycle ready"},
          {30'h0, oErr, oDropped}, 32'h1);
  endtask

  task automatic tRead(input logic be, input logic [31:0] addr, input logic [1:0] sz,
                       input logic [31:0] resp, input string req);
    bigEndian = be;
    access(0, 1, addr, sz, 32'hFFFF_FFFF, resp, 0);
    check(oStrobe && !oWrDir && oAddr == addr[15:0], {req, " R1 R2 read strobe/addr"},
          {15'h0, oStrobe, oAddr}, {16'h1, addr[15:0]});
    check(oRdata == expLane(resp, sz, be), {req, " read data"}, oRdata, expLane(resp, sz, be));
    check(!oErr, {req, " R10 no err"}, {31'h0, oErr}, 32'h0);
  endtask

  task automatic tWaitStates();
    bigEndian = 0;
    access(1, 0, 32'h1400_0300, 2'd2, 32'hCAFE_F00D, 32'h0, 5);
    check(oStrobeCycles == 6, "R6 strobe held through waits", oStrobeCycles, 32'd6);
    check(!oReadyEarly && oDropped, "R6 ready timing", {30'h0, oReadyEarly, oDropped}, 32'h1);
    check(oStrobe && oWdata == 32'hCAFE_F00D, "R6 data during waits", oWdata, 32'hCAFE_F00D);
  endtask

  task automatic tBothStrobes();
    access(1, 1, 32'h1400_0010, 2'd1, 32'h0000_1357, 32'h0, 0);
    check(oWrDir && !oErr, "R10 rd+wr treated as write", {30'h0, oWrDir, oErr}, 32'h2);
  endtask

  task automatic tMissWrite(input logic [31:0] addr);
    access(1, 0, addr, 2'd2, 32'h1234_5678, 32'h0, 0);
    check(!oStrobe, "R7 R1 no strobe on missed write", {31'h0, oStrobe}, 32'h0);
    check(!oErr && oDropped, "R7 ready, no err", {30'h0, oErr, oDropped}, 32'h1);
  endtask

  task automatic tMissRead(input logic [31:0] addr);
    bigEndian = 0;
    access(0, 1, 32'h1400_0020, 2'd2, 32'h0, 32'h5555_AAAA, 0);
    check(oRdata == 32'h5555_AAAA, "R5 primer read", oRdata, 32'h5555_AAAA);
    access(0, 1, addr, 2'd2, 32'h0, 32'hFFFF_FFFF, 0);
    check(!oStrobe, "R8 R1 no strobe on missed read", {31'h0, oStrobe}, 32'h0);
    check(oRdata == 0, "R8 zero data", oRdata, 32'h0);
    check(oErr && oDropped, "R8 one-cycle err", {30'h0, oErr, oDropped}, 32'h3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    tReset();
    @(negedge clk);
    rstN = 1;
    tReset();
    tWrite(0, 32'h1400_0060, 2'd0, 32'hAABB_CC5A, "R3 LE byte");
    tWrite(0, 32'h1400_03F8, 2'd1, 32'h1122_3344, "R3 LE half");
    tWrite(0, 32'h1400_FFFC, 2'd2, 32'hDEAD_BEEF, "R3 LE word edge");
    tWrite(1, 32'h1400_0061, 2'd0, 32'h0000_0077, "R4 BE byte");
    tWrite(1, 32'h1400_0102, 2'd1, 32'h1122_3344, "R4 BE half");
    tWrite(1, 32'h1400_0104, 2'd2, 32'hDEAD_BEEF, "R4 BE word");
    tRead(0, 32'h1400_0040, 2'd0, 32'hFFFF_FF81, "R5 LE byte");
    tRead(0, 32'h1400_0042, 2'd1, 32'h1234_ABCD, "R5 LE half");
    tRead(0, 32'h1400_FFFF, 2'd2, 32'h0102_0304, "R5 LE word edge");
    tRead(1, 32'h1400_0050, 2'd0, 32'h1234_5699, "R5 BE byte");
    tRead(1, 32'h1400_0052, 2'd1, 32'h0000_ABCD, "R5 BE half");
    tRead(1, 32'h1400_0054, 2'd2, 32'h0102_0304, "R5 BE word");
    tWaitStates();
    tBothStrobes();
    tMissWrite(32'h1401_0000);
    tMissWrite(32'h13FF_FFFF);
    tMissRead(32'h13FF_FFFE);
    tMissRead(32'h1401_0000);
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule